// File: doc/BRIEF.md
# SPI Bit-Clock Prescaler with Two Divisor Encodings

This block turns the system clock into the timing strobes that pace an SPI shift engine. It reads the divisor field of the controller's configuration word and produces a leading-edge strobe and a trailing-edge strobe for the serial clock. Each strobe fires once per divide period, and the two are spaced half a period apart.

A static strap input selects how the divisor field is read:

- **Even-only encoding.** Five bits select an even ratio between 4 and 30.
- **Factor-times-power-of-two encoding.** A 4-bit linear factor is shifted left by a 3-bit exponent. The exponent's bits are not adjacent in the configuration word. This gives ratios up to 1920.

A field value that cannot give a usable ratio raises a flag and silences both strobes.

The divisor setting is captured only while the controller is idle (`run` low). A write to the field during a word therefore cannot disturb the serial clock in mid-word. The new value applies from the next word.

Top module: `spi_sck_prescaler`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cfg_bad` is 1, and `lead_stb` and `trail_stb` are 0 regardless of `run`.
- R2: With `variant_ext`=0, a field `cfg_field[4:0]` = 0x10+N with N from 2 to 15 gives a divide ratio of 2·N. Bits [7:5] have no effect.
- R3: With `variant_ext`=0, any `cfg_field[4:0]` below 0x12 (which includes every value with bit 4 clear) is invalid.
- R4: With `variant_ext`=1, the factor F is `cfg_field[3:0]`. The exponent E takes bit 0 from `cfg_field[4]` and bits [2:1] from `cfg_field[7:6]`. The ratio is F·2^E. Bit 5 has no effect.
- R5: With `variant_ext`=1, a field with F=0, or whose ratio is below 4, is invalid. A ratio of exactly 4 is valid.
- R6: An invalid setting drives `cfg_bad` to 1 and keeps both strobes at 0 even while `run` is high. A valid setting drives `cfg_bad` to 0.
- R7: Number the cycles of a word from j=0, the first cycle in which `run` is high after an idle cycle, and let R be the ratio. `lead_stb` is 1 exactly when j mod R = R/2−1 (integer division). `trail_stb` is 1 exactly when j mod R = R−1. The two strobes are never high together.
- R8: Changes to `cfg_field` or `variant_ext` while `run` is high are ignored for that word. The values present in the last idle cycle before `run` rises apply to the whole word.
- R9: Dropping `run` resets the strobe phase. The next word starts again at j=0, whatever point the previous word had reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| variant_ext | input | 1 | Encoding strap: 0 even-only, 1 factor-times-power-of-two |
| cfg_field | input | 8 | Divisor bits of the configuration word |
| run | input | 1 | High while a word is being shifted; low when idle |
| lead_stb | output | 1 | One-cycle strobe at the serial clock's leading edge |
| trail_stb | output | 1 | One-cycle strobe at the serial clock's trailing edge |
| cfg_bad | output | 1 | Captured divisor setting is unusable |

## Verification
The embedded properties check several rules on every cycle:

- an invalid capture never lets a strobe through;
- the two strobes never coincide;
- the period counter stays below the captured ratio and wraps to zero right after each trailing strobe;
- the captured setting stays frozen while a word is active;
- any decode marked valid has a ratio of at least four.

Only the bench's scenarios can show that the exact ratio and the position of each strobe within the period match both field encodings. They do this across the boundary values, the ignored bits, the scattered exponent bits, the mid-word field change and the restart of the phase after an interrupted word.

// File: rtl/spi_psc_pkg.sv
package spi_psc_pkg;

    localparam int CFG_W     = 8;
    localparam int FACTOR_W  = 4;
    localparam int EXP_W     = 3;
    localparam int RATIO_W   = FACTOR_W + (1 << EXP_W) - 1;
    localparam int MIN_RATIO = 4;
    localparam int LEG_N_W   = 4;

    typedef enum logic {
        ENC_EVEN  = 1'b0,
        ENC_SHIFT = 1'b1
    } enc_e;

    typedef struct packed {
        logic               bad;
        logic [RATIO_W-1:0] ratio;
    } div_cfg_t;

    // Even-only encoding: bit 4 marks a programmed value, bits [3:0] give N, ratio 2N.
    function automatic div_cfg_t decode_even(input logic [CFG_W-1:0] f);
        div_cfg_t r;
        logic [LEG_N_W-1:0] n;
        n       = f[LEG_N_W-1:0];
        r.ratio = RATIO_W'({n, 1'b0});
        r.bad   = !f[LEG_N_W] || (r.ratio < RATIO_W'(MIN_RATIO));
        return r;
    endfunction

    // Shifted encoding: factor in [3:0], exponent gathered from bits 7,6 and 4.
    function automatic div_cfg_t decode_shift(input logic [CFG_W-1:0] f);
        div_cfg_t r;
        logic [FACTOR_W-1:0] fac;
        logic [EXP_W-1:0]    ex;
        fac     = f[FACTOR_W-1:0];
        ex      = {f[7:6], f[4]};
        r.ratio = RATIO_W'(fac) << ex;
        r.bad   = (fac == '0) || (r.ratio < RATIO_W'(MIN_RATIO));
        return r;
    endfunction

endpackage

// File: rtl/psc_decode.sv
module psc_decode
    import spi_psc_pkg::*;
(
    input  enc_e             enc,
    input  logic [CFG_W-1:0] field,
    output div_cfg_t         dec
);
    div_cfg_t dec_even;
    div_cfg_t dec_shift;

    always_comb begin
        dec_even  = decode_even(field);
        dec_shift = decode_shift(field);
        dec       = (enc == ENC_SHIFT) ? dec_shift : dec_even;
    end
endmodule

// File: rtl/psc_cfg_hold.sv
module psc_cfg_hold
    import spi_psc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  div_cfg_t d,
    output div_cfg_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q.bad   <= 1'b1;
            q.ratio <= RATIO_W'(MIN_RATIO);
        end else if (!run) begin
            q <= d;
        end
    end

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!rst && run) |=> $stable(q)); // R8
endmodule

// File: rtl/psc_edge_gen.sv
module psc_edge_gen
    import spi_psc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  div_cfg_t cfg,
    output logic     lead,
    output logic     trail
);
    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] last_idx;
    logic [RATIO_W-1:0] mid_idx;
    logic               active;

    always_comb begin
        active   = run && !cfg.bad;
        last_idx = cfg.ratio - RATIO_W'(1);
        mid_idx  = (cfg.ratio >> 1) - RATIO_W'(1);
        lead     = active && (cnt == mid_idx);
        trail    = active && (cnt == last_idx);
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else if (cnt == last_idx) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + RATIO_W'(1);
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(lead && trail)); // R7
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        !cfg.bad |-> (cnt < cfg.ratio)); // R7
    AST_TRAIL_WRAP: assert property (@(posedge clk) disable iff (rst)
        trail |=> (cnt == '0)); // R7
endmodule

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler
    import spi_psc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             variant_ext,
    input  logic [CFG_W-1:0] cfg_field,
    input  logic             run,
    output logic             lead_stb,
    output logic             trail_stb,
    output logic             cfg_bad
);
    enc_e     enc;
    div_cfg_t dec_now;
    div_cfg_t dec_held;

    assign enc = enc_e'(variant_ext);

    psc_decode u_decode (
        .enc   (enc),
        .field (cfg_field),
        .dec   (dec_now)
    );

    psc_cfg_hold u_hold (
        .clk (clk),
        .rst (rst),
        .run (run),
        .d   (dec_now),
        .q   (dec_held)
    );

    psc_edge_gen u_edges (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .cfg   (dec_held),
        .lead  (lead_stb),
        .trail (trail_stb)
    );

    assign cfg_bad = dec_held.bad;

    AST_BAD_SILENT: assert property (@(posedge clk) disable iff (rst)
        cfg_bad |-> (!lead_stb && !trail_stb)); // R6
    AST_DECODE_FLOOR: assert property (@(posedge clk) disable iff (rst)
        !dec_now.bad |-> (dec_now.ratio >= RATIO_W'(MIN_RATIO))); // R5
    AST_HELD_FLOOR: assert property (@(posedge clk) disable iff (rst)
        !cfg_bad |-> (dec_held.ratio >= RATIO_W'(MIN_RATIO))); // R5
endmodule

// File: tb/sim_spi_sck_prescaler.sv
module sim_spi_sck_prescaler;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CAP   = 700;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       variant_ext = 1'b0;
    logic [7:0] cfg_field = 8'h00;
    logic       run = 1'b0;
    logic       lead_stb, trail_stb, cfg_bad;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_sck_prescaler u0 (
        .clk         (clk),
        .rst         (rst),
        .variant_ext (variant_ext),
        .cfg_field   (cfg_field),
        .run         (run),
        .lead_stb    (lead_stb),
        .trail_stb   (trail_stb),
        .cfg_bad     (cfg_bad)
    );

    // Expected ratio, 0 when the field is unusable (R2..R5).
    function automatic int exp_ratio(input bit ext, input logic [7:0] f);
        int fac, ex, r;
        if (!ext) begin
            if (int'(f & 8'h1F) < 18) return 0;
            return (int'(f & 8'h1F) - 16) * 2;
        end
        fac = int'(f & 8'h0F);
        ex  = ((int'(f) >> 6) & 3) * 2 + ((int'(f) >> 4) & 1);
        r   = fac * (1 << ex);
        if (fac == 0 || r < 4) return 0;
        return r;
    endfunction

    task automatic window(input string req, input bit ext, input logic [7:0] f,
                          input int ncyc, input int chg_at, input logic [7:0] f2);
        int  r;
        bit  seen;
        bit  el, et, eb;
        r    = exp_ratio(ext, f);
        seen = 1'b0;
        variant_ext = ext;
        cfg_field   = f;
        run         = 1'b0;
        @(posedge clk); #1;
        run = 1'b1;
        for (int j = 0; j < ncyc; j++) begin
            @(negedge clk);
            eb = (r == 0);
            el = !eb && ((j % (eb ? 1 : r)) == r/2 - 1);
            et = !eb && ((j % (eb ? 1 : r)) == r - 1);
            if (!seen && (lead_stb !== el || trail_stb !== et || cfg_bad !== eb)) begin
                seen = 1'b1;
                $display("FAIL %s: ext=%0b field=%02h cycle %0d lead=%0b exp %0b trail=%0b exp %0b bad=%0b exp %0b",
                         req, ext, f, j, lead_stb, el, trail_stb, et, cfg_bad, eb);
            end
            @(posedge clk); #1;
            if (j == chg_at) begin
                cfg_field   = f2;
                variant_ext = ~ext;
            end
        end
        run = 1'b0;
        tests++;
        if (seen) fails++;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not end, actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        // R1: reset state, even with run high
        run = 1'b1;
        cfg_field = 8'h12;
        repeat (3) @(posedge clk);
        @(negedge clk);
        tests++;
        if (cfg_bad !== 1'b1 || lead_stb !== 1'b0 || trail_stb !== 1'b0) begin
            fails++;
            $display("FAIL R1: bad=%0b lead=%0b trail=%0b expected 1 0 0", cfg_bad, lead_stb, trail_stb);
        end
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        tests++;
        if (cfg_bad !== 1'b1 || lead_stb !== 1'b0 || trail_stb !== 1'b0) begin
            fails++;
            $display("FAIL R1: after release bad=%0b lead=%0b trail=%0b expected 1 0 0", cfg_bad, lead_stb, trail_stb);
        end
        @(posedge clk); #1;
        run = 1'b0;

        // R2 even encoding, R7 strobe placement
        window("R2", 1'b0, 8'h12, 12, -1, 8'h00);
        window("R2", 1'b0, 8'h1F, 65, -1, 8'h00);
        window("R2", 1'b0, 8'hF5, 25, -1, 8'h00);   // upper bits ignored
        window("R7", 1'b0, 8'h17, 30, -1, 8'h00);
        // R3 invalid even fields
        window("R3", 1'b0, 8'h11, 10, -1, 8'h00);
        window("R3", 1'b0, 8'h0A, 10, -1, 8'h00);
        window("R3", 1'b0, 8'hE0, 10, -1, 8'h00);
        // R4 shifted encoding
        window("R4", 1'b1, 8'h04, 12, -1, 8'h00);
        window("R4", 1'b1, 8'h0F, 35, -1, 8'h00);   // odd ratio 15
        window("R4", 1'b1, 8'h3F, 65, -1, 8'h00);   // bit 5 ignored, ratio 30
        window("R4", 1'b1, 8'hC1, 140, -1, 8'h00);  // exponent 6, ratio 64
        window("R4", 1'b1, 8'hDF, 1925, -1, 8'h00); // ratio 1920
        // R5 invalid and floor
        window("R5", 1'b1, 8'hD0, 10, -1, 8'h00);
        window("R5", 1'b1, 8'h01, 10, -1, 8'h00);
        window("R5", 1'b1, 8'h03, 10, -1, 8'h00);
        window("R5", 1'b1, 8'h11, 10, -1, 8'h00);
        window("R5", 1'b1, 8'h41, 12, -1, 8'h00);   // ratio exactly 4
        // R6 invalid stays silent over a long run
        window("R6", 1'b0, 8'h10, 40, -1, 8'h00);
        // R8 change during a word ignored, then applied
        window("R8", 1'b0, 8'h14, 30, 3, 8'h0F);
        window("R8", 1'b1, 8'h0F, 35, -1, 8'h00);
        // R9 interrupted word then restart from phase 0
        window("R9", 1'b0, 8'h16, 5, -1, 8'h00);
        window("R9", 1'b0, 8'h16, 20, -1, 8'h00);

        // random mix (R2..R7)
        for (int k = 0; k < 30; k++) begin
            bit         ext;
            logic [7:0] f;
            int         r, n;
            ext = 1'($urandom);
            f   = 8'($urandom);
            r   = exp_ratio(ext, f);
            n   = (r == 0) ? 10 : ((2*r + 3 > RAND_CAP) ? RAND_CAP : 2*r + 3);
            window(ext ? "R4 R5 R7 random" : "R2 R3 R7 random", ext, f, n, -1, 8'h00);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule